// File: doc/BRIEF.md
# BCD Calendar Clock Register Bank

This block keeps a running calendar and time of day in packed BCD: century, year, month, date, weekday, hour, minute and second. Each pulse on the one-per-second tick input advances the internal counters by one second. Carries run through minutes, hours (24-hour), days, months of varying length including February in leap years, years and the century byte.

Host software does not see the counters directly. It sees a set of shadow bytes at the top sixteen addresses of a byte-addressed window. The block refreshes the shadow bytes from the counters on every tick. A control byte can freeze the shadow bytes so they can be read consistently. The control byte can also hold them while software writes a new time, and then copy that time into the counters when software clears the hold bit. Access goes through a synchronous byte port. A read returns its data one clock after the request.

Top module: `rtc_calendar_bank`

## Requirements
- R1: After reset, the shadow bytes read century 20h, year 00h, month 01h, date 01h, weekday 01h, hour/minute/second 00h. The control byte reads 00h.
- R2: An access hits the bank only when all address bits above the low four are ones. Low nibbles map as follows: Fh year, Eh month, Dh date, Ch weekday, Bh hour, Ah minute, 9h second, 8h control, 1h century. Other nibbles read 00h. Reads return data on `rdata` one clock after a cycle with `sel`=1 and `wr`=0. Accesses outside the top page read 00h, and their writes change nothing.
- R3: Each tick advances seconds 00..59 in BCD. The carry passes into minutes 00..59 and then into hours 00..23.
- R4: When the hour wraps from 23 to 00, the date advances and the weekday advances from 1 to 7 and then back to 1.
- R5: Months 04h, 06h, 09h and 11h end on day 30h. Month 02h ends on 29h when the BCD year is divisible by four, and on 28h otherwise. All other months end on 31h. The date after the last day is 01h and the month advances.
- R6: Month 12h wraps to 01h and increments the year. Year 99h wraps to 00h and increments the BCD century.
- R7: When control bits 7 and 6 are both 0, each tick loads the shadow bytes with the advanced time.
- R8: While control bit 7 is 1, the shadow bytes do not refresh but the counters keep counting. After the bit is cleared, the next tick shows the time including every tick that occurred during the freeze.
- R9: While control bit 6 is 1, the shadow bytes do not refresh. A control write that changes bit 6 from 1 to 0 copies the shadow bytes into the counters. A tick in that same cycle advances the copied time by one second.
- R10: A host write to a shadow byte in the same cycle as a refresh keeps the written value and leaves the counters untouched.
- R11: Control bits 5..0 are stored and read back, and they have no effect on counting or refresh.
- R12: A counter whose value lies at or above its maximum wraps at its next advance, so values software writes out of range return to the legal range. For example, second 75h followed by a tick gives second 00h and a minute carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Access request |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte address in the window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| tick | input | 1 | One-cycle pulse once per second |

## Verification
Two pairs of functions can fall in the same clock cycle. In the first, a tick arrives in the very cycle that software clears the load bit. The bench drives the control write and the tick on the same edge. It expects the shadow byte to keep the loaded second, because the refresh is still held, and the next tick to show that second plus two. In the second, a shadow write lands on an unfrozen refresh tick. The bench expects the written byte to survive, and the following tick to show the untouched counter time.

// File: rtl/rtc_calendar_bank.sv
module rtc_calendar_bank #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              tick
);
  localparam logic [ADDR_W-5:0] PAGE = '1;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] >= 4'h9) ? {v[7:4] + 4'h1, 4'h0} : v + 8'h01;
  endfunction

  function automatic logic [7:0] wrap_inc(input logic [7:0] v, input logic [7:0] top,
                                          input logic [7:0] low);
    return (v >= top) ? low : bcd_inc(v);
  endfunction

  function automatic logic [7:0] month_end(input logic [7:0] m, input logic [7:0] y);
    logic leap;
    leap = y[4] ? (y[3:0] == 4'h2 || y[3:0] == 4'h6)
                : (y[3:0] == 4'h0 || y[3:0] == 4'h4 || y[3:0] == 4'h8);
    case (m)
      8'h02: return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction

  logic [7:0] sec_c, min_c, hour_c, day_c, date_c, mon_c, year_c, cent_c;
  logic [7:0] sec_s, min_s, hour_s, day_s, date_s, mon_s, year_s, cent_s;
  logic [7:0] ctrl_q;

  wire        hit    = sel && (addr[ADDR_W-1:4] == PAGE);
  wire [3:0]  off    = addr[3:0];
  wire        hwr    = hit && wr;
  wire        load   = hwr && off == 4'h8 && ctrl_q[6] && !wdata[6];
  wire        rf     = tick && !ctrl_q[7] && !ctrl_q[6];

  wire [7:0] b_sec  = load ? sec_s  : sec_c;
  wire [7:0] b_min  = load ? min_s  : min_c;
  wire [7:0] b_hour = load ? hour_s : hour_c;
  wire [7:0] b_day  = load ? day_s  : day_c;
  wire [7:0] b_date = load ? date_s : date_c;
  wire [7:0] b_mon  = load ? mon_s  : mon_c;
  wire [7:0] b_year = load ? year_s : year_c;
  wire [7:0] b_cent = load ? cent_s : cent_c;

  wire c_s  = tick && b_sec  >= 8'h59;
  wire c_m  = c_s  && b_min  >= 8'h59;
  wire c_h  = c_m  && b_hour >= 8'h23;
  wire c_d  = c_h  && b_date >= month_end(b_mon, b_year);
  wire c_mo = c_d  && b_mon  >= 8'h12;
  wire c_y  = c_mo && b_year >= 8'h99;

  wire [7:0] n_sec  = tick ? wrap_inc(b_sec,  8'h59, 8'h00) : b_sec;
  wire [7:0] n_min  = c_s  ? wrap_inc(b_min,  8'h59, 8'h00) : b_min;
  wire [7:0] n_hour = c_m  ? wrap_inc(b_hour, 8'h23, 8'h00) : b_hour;
  wire [7:0] n_day  = c_h  ? wrap_inc(b_day,  8'h07, 8'h01) : b_day;
  wire [7:0] n_date = c_h  ? (c_d ? 8'h01 : bcd_inc(b_date)) : b_date;
  wire [7:0] n_mon  = c_d  ? wrap_inc(b_mon,  8'h12, 8'h01) : b_mon;
  wire [7:0] n_year = c_mo ? wrap_inc(b_year, 8'h99, 8'h00) : b_year;
  wire [7:0] n_cent = c_y  ? wrap_inc(b_cent, 8'h99, 8'h00) : b_cent;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_c <= 8'h00; min_c <= 8'h00; hour_c <= 8'h00; day_c <= 8'h01;
      date_c <= 8'h01; mon_c <= 8'h01; year_c <= 8'h00; cent_c <= 8'h20;
    end else begin
      sec_c <= n_sec; min_c <= n_min; hour_c <= n_hour; day_c <= n_day;
      date_c <= n_date; mon_c <= n_mon; year_c <= n_year; cent_c <= n_cent;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_s <= 8'h00; min_s <= 8'h00; hour_s <= 8'h00; day_s <= 8'h01;
      date_s <= 8'h01; mon_s <= 8'h01; year_s <= 8'h00; cent_s <= 8'h20;
      ctrl_q <= 8'h00;
    end else begin
      if (rf) begin
        sec_s <= n_sec; min_s <= n_min; hour_s <= n_hour; day_s <= n_day;
        date_s <= n_date; mon_s <= n_mon; year_s <= n_year; cent_s <= n_cent;
      end
      if (hwr) begin
        case (off)
          4'hF: year_s <= wdata;
          4'hE: mon_s  <= wdata;
          4'hD: date_s <= wdata;
          4'hC: day_s  <= wdata;
          4'hB: hour_s <= wdata;
          4'hA: min_s  <= wdata;
          4'h9: sec_s  <= wdata;
          4'h8: ctrl_q <= wdata;
          4'h1: cent_s <= wdata;
          default: ;
        endcase
      end
    end
  end

  logic [7:0] rmux;
  always_comb begin
    case (off)
      4'hF: rmux = year_s;
      4'hE: rmux = mon_s;
      4'hD: rmux = date_s;
      4'hC: rmux = day_s;
      4'hB: rmux = hour_s;
      4'hA: rmux = min_s;
      4'h9: rmux = sec_s;
      4'h8: rmux = ctrl_q;
      4'h1: rmux = cent_s;
      default: rmux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= 8'h00;
    else if (sel && !wr) rdata <= hit ? rmux : 8'h00;
  end
endmodule

module rtc_calendar_bank_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel,
  input logic              wr,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        rdata,
  input logic              tick,
  input logic              load,
  input logic [7:0]        cnt_sec,
  input logic [7:0]        cnt_hour,
  input logic [7:0]        sh_sec,
  input logic [7:0]        ctrl
);
  localparam logic [ADDR_W-1:0] SEC_A = {{(ADDR_W-4){1'b1}}, 4'h9};

  assert_sec_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && cnt_sec <= 8'h59) |=> cnt_sec <= 8'h59);
  assert_hour_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && cnt_hour <= 8'h23) |=> cnt_hour <= 8'h23);
  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt_sec));
  assert_refresh_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ctrl[7] && !ctrl[6] && !(sel && wr)) |=> sh_sec == cnt_sec);
  assert_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[7] && !(sel && wr)) |=> $stable(sh_sec));
  assert_read_lat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !wr && addr == SEC_A) |=> rdata == $past(sh_sec));
endmodule

bind rtc_calendar_bank rtc_calendar_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr), .rdata(rdata),
  .tick(tick), .load(load), .cnt_sec(sec_c), .cnt_hour(hour_c),
  .sh_sec(sec_s), .ctrl(ctrl_q)
);

// File: tb/tb_rtc_calendar_bank.sv
`timescale 1ns/1ps
module tb_rtc_calendar_bank;
  localparam int AW = 17;
  localparam int NV = 13;
  // {start cent,year,mon,date,day,hour,min,sec , expected after one tick}
  localparam logic [127:0] VEC [NV] = '{
    {64'h20_24_03_15_03_10_20_30, 64'h20_24_03_15_03_10_20_31},
    {64'h20_24_03_15_03_10_20_59, 64'h20_24_03_15_03_10_21_00},
    {64'h20_24_03_15_03_10_59_59, 64'h20_24_03_15_03_11_00_00},
    {64'h20_24_03_15_07_23_59_59, 64'h20_24_03_16_01_00_00_00},
    {64'h20_24_02_28_02_23_59_59, 64'h20_24_02_29_03_00_00_00},
    {64'h20_24_02_29_03_23_59_59, 64'h20_24_03_01_04_00_00_00},
    {64'h20_23_02_28_02_23_59_59, 64'h20_23_03_01_03_00_00_00},
    {64'h20_25_04_30_05_23_59_59, 64'h20_25_05_01_06_00_00_00},
    {64'h20_25_05_30_05_23_59_59, 64'h20_25_05_31_06_00_00_00},
    {64'h20_25_12_31_04_23_59_59, 64'h20_26_01_01_05_00_00_00},
    {64'h20_99_12_31_06_23_59_59, 64'h21_00_01_01_07_00_00_00},
    {64'h20_00_02_28_01_23_59_59, 64'h20_00_02_29_02_00_00_00},
    {64'h20_26_06_30_02_23_59_59, 64'h20_26_07_01_03_00_00_00}
  };
  localparam logic [3:0] OFFS [8] = '{4'h1, 4'hF, 4'hE, 4'hD, 4'hC, 4'hB, 4'hA, 4'h9};

  logic clk = 0, rst_n = 0, sel = 0, wr = 0, tick = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rtc_calendar_bank #(.ADDR_W(AW)) dut (.clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr),
    .addr(addr), .wdata(wdata), .rdata(rdata), .tick(tick));

  function automatic logic [AW-1:0] top(input logic [3:0] o);
    return {{(AW-4){1'b1}}, o};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hw(input logic [AW-1:0] a, input logic [7:0] d, input logic tk);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d; tick = tk;
    @(negedge clk); sel = 0; wr = 0; tick = 0;
  endtask

  task automatic hr(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk); sel = 1; wr = 0; addr = a;
    @(negedge clk); sel = 0; d = rdata;
  endtask

  task automatic pulse();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  task automatic rd_all(output logic [63:0] t);
    logic [7:0] b;
    for (int i = 0; i < 8; i++) begin
      hr(top(OFFS[i]), b);
      t[63-8*i -: 8] = b;
    end
  endtask

  task automatic set_time(input logic [63:0] t);
    hw(top(4'h8), 8'h40, 0);
    for (int i = 0; i < 8; i++) hw(top(OFFS[i]), t[63-8*i -: 8], 0);
    hw(top(4'h8), 8'h00, 0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] t;
    logic [7:0] b;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd_all(t); chk("R1 reset time", t, 64'h20_00_01_01_01_00_00_00);
    hr(top(4'h8), b); chk("R1 reset ctrl", {56'h0, b}, 64'h0);

    hr(top(4'h0), b); chk("R2 unmapped nibble", {56'h0, b}, 64'h0);
    hw(17'h00009, 8'h55, 0);
    hr(top(4'h9), b); chk("R2 outside page write ignored", {56'h0, b}, 64'h0);
    hr(17'h00009, b); chk("R2 outside page read", {56'h0, b}, 64'h0);

    // R3 R4 R5 R6 R7: vector walk
    for (int v = 0; v < NV; v++) begin
      set_time(VEC[v][127:64]);
      pulse();
      rd_all(t);
      chk($sformatf("R3-6 vector %0d", v), t, VEC[v][63:0]);
    end

    set_time(64'h20_25_01_10_01_05_10_75);
    pulse(); rd_all(t);
    chk("R12 out of range second", t, 64'h20_25_01_10_01_05_11_00);

    set_time(64'h20_25_01_10_01_05_10_10);
    hw(top(4'h8), 8'h80, 0);
    repeat (3) pulse();
    hr(top(4'h9), b); chk("R8 frozen shadow", {56'h0, b}, 64'h10);
    hw(top(4'h8), 8'h00, 0);
    pulse();
    hr(top(4'h9), b); chk("R8 catch up after freeze", {56'h0, b}, 64'h14);

    set_time(64'h20_25_01_10_01_05_10_20);
    hw(top(4'h8), 8'h40, 0);
    pulse();
    hr(top(4'h9), b); chk("R9 hold bit blocks refresh", {56'h0, b}, 64'h20);
    hw(top(4'h9), 8'h05, 0);
    hw(top(4'h8), 8'h00, 1);
    hr(top(4'h9), b); chk("R9 load with tick shadow", {56'h0, b}, 64'h05);
    pulse();
    hr(top(4'h9), b); chk("R9 loaded plus tick", {56'h0, b}, 64'h07);

    hw(top(4'h9), 8'h33, 1);
    hr(top(4'h9), b); chk("R10 write beats refresh", {56'h0, b}, 64'h33);
    pulse();
    hr(top(4'h9), b); chk("R10 counters untouched", {56'h0, b}, 64'h09);

    hw(top(4'h8), 8'h15, 0);
    hr(top(4'h8), b); chk("R11 ctrl low bits stored", {56'h0, b}, 64'h15);
    pulse();
    hr(top(4'h9), b); chk("R11 low bits no effect", {56'h0, b}, 64'h10);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule